// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers the eight interrupt causes of a two-channel serial controller into one readable status byte and drives a single active-low interrupt line. There are four kinds of cause. The first is a change seen on the general-purpose input pins. The second is a break starting or ending on either receiver. The third is the counter/timer reaching its event. The fourth is the receive and transmit service requests of each channel. Each cause has its own rule for setting and clearing. The request bits follow live levels. The event bits are sticky and are cleared only by their own strobe: a read of the input-change register, a per-channel break-change reset command, or a stop-counter command.

The CPU writes an 8-bit enable mask. The interrupt line goes low when any status bit is set and its mask bit is also set. The mask never alters the status byte the CPU reads back. A two-state machine drives the line. In state `IRQ_IDLE` the line is high. The machine moves to `IRQ_ACTIVE` (line low) when some masked status bit is set, and returns to `IRQ_IDLE` when none is. The move is registered, so the line trails the status byte by one clock.

Top module: `irq_status_unit`

## Requirements
- R1: The status byte, from bit 7 down to bit 0, is: input-pin change, channel B break change, channel B receive request, channel B transmit request, counter ready, channel A break change, channel A receive request, channel A transmit request.
- R2: Bit 7 sets one clock after an input pin differs from its value one clock earlier while that pin's bit in `ip_chg_en` is 1. The first sample taken after reset is never counted as a change.
- R3: A change on a pin whose `ip_chg_en` bit is 0 leaves bit 7 unchanged.
- R4: Each sticky event bit (7, 6, 3, 2) clears one clock after its clear strobe. Bit 7 clears on `ipcr_rd`, bit 6 on `brk_clr_b`, bit 3 on `ct_stop` and bit 2 on `brk_clr_a`. When a set and a clear arrive in the same cycle, the bit ends up set.
- R5: A break-change bit sets on its own channel's `brk_evt` pulse. It is not cleared by the other channel's clear command.
- R6: Counter ready (bit 3) sets on a `ct_ready` pulse and stays set until `ct_stop`.
- R7: Request bits 5, 4, 1 and 0 equal the `rx_req_b`, `tx_req_b`, `rx_req_a` and `tx_req_a` levels sampled at the previous clock.
- R8: `irq_n` is 0 one clock after the status byte ANDed with the mask is nonzero, and 1 one clock after that AND is zero.
- R9: A set status bit whose mask bit is 0 does not drive `irq_n` low.
- R10: The mask value has no effect on `status_o`.
- R11: While and after reset, `status_o` is 0x00, the mask is 0x00 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ip_pins | input | PORT_PINS | Synchronised input pin levels |
| ip_chg_en | input | PORT_PINS | Per-pin change-interrupt enable |
| ipcr_rd | input | 1 | Strobe: CPU read of the input-change register |
| brk_evt_a | input | 1 | Pulse: channel A break began or ended |
| brk_evt_b | input | 1 | Pulse: channel B break began or ended |
| brk_clr_a | input | 1 | Strobe: channel A reset-break-change command |
| brk_clr_b | input | 1 | Strobe: channel B reset-break-change command |
| ct_ready | input | 1 | Pulse: counter/timer event |
| ct_stop | input | 1 | Strobe: stop-counter command |
| rx_req_a | input | 1 | Level: channel A receive request |
| tx_req_a | input | 1 | Level: channel A transmit request |
| rx_req_b | input | 1 | Level: channel B receive request |
| tx_req_b | input | 1 | Level: channel B transmit request |
| mask_wr | input | 1 | Strobe: load the mask register |
| mask_din | input | 8 | Mask value to load |
| status_o | output | 8 | Readable status byte |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
The masking function is tried with three patterns. In the first, a single status bit is set under a mask that selects it and then under one that does not, which tests the per-bit AND. In the second, several bits are set while the mask selects only one of them, which shows that unselected bits neither raise the line nor change the readback. In the third, the mask is written in the same cycle as a new event, which shows the one-clock lag between the status byte and the line. Sticky bits are driven with set-only, clear-only, and set-and-clear-together strobes, along with the other channel's clear, to tell the per-source clear rules apart. Input pins are toggled both with enabled and with disabled pins, and are held non-zero across a reset.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int STATUS_W  = 8;
    localparam int BIT_IPCHG = 7;
    localparam int BIT_BRK_B = 6;
    localparam int BIT_RX_B  = 5;
    localparam int BIT_TX_B  = 4;
    localparam int BIT_CTRDY = 3;
    localparam int BIT_BRK_A = 2;
    localparam int BIT_RX_A  = 1;
    localparam int BIT_TX_A  = 0;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_line_state_e;

endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end

    // R4: a set, even with a simultaneous clear, leaves the bit set
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R4: a lone clear drops the bit
    p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/irq_port_change.sv
module irq_port_change #(
    parameter int PORT_PINS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_PINS-1:0] pins_i,
    input  logic [PORT_PINS-1:0] en_i,
    output logic                 chg_o
);

    logic [PORT_PINS-1:0] prev_q;
    logic                 primed_q;
    logic [PORT_PINS-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pins_i;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        diff  = (pins_i ^ prev_q) & en_i;
        chg_o = primed_q && (diff != '0);
    end

    // R2: no change is reported before a first sample exists
    p_no_change_unprimed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_q |-> !chg_o);

    // R3: a change only on disabled pins is not reported
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((pins_i ^ prev_q) & ~en_i) != '0 && ((pins_i ^ prev_q) & en_i) == '0) |-> !chg_o);

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_i,
    input  logic [STATUS_W-1:0] mask_i,
    output logic                irq_n
);

    irq_line_state_e state_q;
    irq_line_state_e state_d;
    logic            pending;

    assign pending = |(status_i & mask_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!pending) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_n = (state_q != IRQ_ACTIVE);
    end

    // R8: a masked pending bit drives the line low one clock later
    p_line_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> !irq_n);

    // R9: with no selected bit set, the line is high one clock later
    p_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> irq_n);

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int PORT_PINS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_PINS-1:0] ip_pins,
    input  logic [PORT_PINS-1:0] ip_chg_en,
    input  logic                 ipcr_rd,
    input  logic                 brk_evt_a,
    input  logic                 brk_evt_b,
    input  logic                 brk_clr_a,
    input  logic                 brk_clr_b,
    input  logic                 ct_ready,
    input  logic                 ct_stop,
    input  logic                 rx_req_a,
    input  logic                 tx_req_a,
    input  logic                 rx_req_b,
    input  logic                 tx_req_b,
    input  logic                 mask_wr,
    input  logic [7:0]           mask_din,
    output logic [7:0]           status_o,
    output logic                 irq_n
);

    localparam int EVT_N = 4;
    localparam int REQ_N = 4;

    logic                port_chg;
    logic [EVT_N-1:0]    evt_set;
    logic [EVT_N-1:0]    evt_clr;
    logic [EVT_N-1:0]    evt_q;
    logic [REQ_N-1:0]    req_q;
    logic [STATUS_W-1:0] mask_q;

    irq_port_change #(.PORT_PINS(PORT_PINS)) u_port_chg (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (ip_pins),
        .en_i   (ip_chg_en),
        .chg_o  (port_chg)
    );

    // event order: [3] pin change, [2] break B, [1] counter, [0] break A
    assign evt_set = {port_chg, brk_evt_b, ct_ready, brk_evt_a};
    assign evt_clr = {ipcr_rd,  brk_clr_b, ct_stop,  brk_clr_a};

    for (genvar g = 0; g < EVT_N; g++) begin : g_evt
        irq_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_set[g]),
            .clr_i (evt_clr[g]),
            .q_o   (evt_q[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            mask_q <= '0;
        end else begin
            req_q <= {rx_req_b, tx_req_b, rx_req_a, tx_req_a};
            if (mask_wr) begin
                mask_q <= mask_din;
            end
        end
    end

    always_comb begin
        status_o            = '0;
        status_o[BIT_IPCHG] = evt_q[3];
        status_o[BIT_BRK_B] = evt_q[2];
        status_o[BIT_RX_B]  = req_q[3];
        status_o[BIT_TX_B]  = req_q[2];
        status_o[BIT_CTRDY] = evt_q[1];
        status_o[BIT_BRK_A] = evt_q[0];
        status_o[BIT_RX_A]  = req_q[1];
        status_o[BIT_TX_A]  = req_q[0];
    end

    irq_line_fsm u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_o),
        .mask_i   (mask_q),
        .irq_n    (irq_n)
    );

    // R2: a detected pin change shows in bit 7 next clock
    p_ipchg_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        port_chg |=> status_o[BIT_IPCHG]);

    // R5: channel A break bit is untouched without its own set or clear
    p_brk_a_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_evt_a && !brk_clr_a) |=> (status_o[BIT_BRK_A] == $past(status_o[BIT_BRK_A])));

    // R6: counter ready holds until stop
    p_ctrdy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[BIT_CTRDY] && !ct_stop) |=> status_o[BIT_CTRDY]);

    // R7: request bits are one-clock copies of the levels
    p_req_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({status_o[BIT_RX_B], status_o[BIT_TX_B], status_o[BIT_RX_A], status_o[BIT_TX_A]}
                  == $past({rx_req_b, tx_req_b, rx_req_a, tx_req_a})));

endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 22;

    // vector: pins[36:33] en[32:29] {rd,ba,bb,ca,cb,cr,cs}[28:22]
    //         {rxb,txb,rxa,txa}[21:18] mw[17] mask[16:9] exp_status[8:1] exp_irq_n[0]
    localparam logic [36:0] VEC [NVEC] = '{
        {4'h0, 4'hF, 7'b0000000, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}, // idle
        {4'h1, 4'hF, 7'b0000000, 4'b0000, 1'b0, 8'h00, 8'h80, 1'b1}, // R2 pin0 rise, R9 masked
        {4'h1, 4'hF, 7'b0000000, 4'b0000, 1'b1, 8'h80, 8'h80, 1'b0}, // R8 mask selects bit7
        {4'h1, 4'hF, 7'b1000000, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}, // R4 read clears
        {4'h0, 4'hE, 7'b0000000, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}, // R3 disabled pin
        {4'h2, 4'hE, 7'b0000000, 4'b0000, 1'b0, 8'h00, 8'h80, 1'b0}, // R2 pin1
        {4'h6, 4'hE, 7'b1000000, 4'b0000, 1'b0, 8'h00, 8'h80, 1'b0}, // R4 set wins
        {4'h6, 4'hE, 7'b1000000, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}, // R4 clear
        {4'h6, 4'hE, 7'b0100000, 4'b0000, 1'b1, 8'h04, 8'h04, 1'b0}, // R5 break A
        {4'h6, 4'hE, 7'b0000100, 4'b0000, 1'b0, 8'h00, 8'h04, 1'b0}, // R5 clear B leaves A
        {4'h6, 4'hE, 7'b0010000, 4'b0000, 1'b0, 8'h00, 8'h44, 1'b0}, // R5 break B
        {4'h6, 4'hE, 7'b0001000, 4'b0000, 1'b0, 8'h00, 8'h40, 1'b1}, // R4 clear A, R9
        {4'h6, 4'hE, 7'b0010100, 4'b0000, 1'b0, 8'h00, 8'h40, 1'b1}, // R4 set wins B
        {4'h6, 4'hE, 7'b0000100, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}, // R4 clear B
        {4'h6, 4'hE, 7'b0000011, 4'b0000, 1'b0, 8'h00, 8'h08, 1'b1}, // R6 set wins stop
        {4'h6, 4'hE, 7'b0000000, 4'b0000, 1'b1, 8'hFF, 8'h08, 1'b0}, // R8 full mask
        {4'h6, 4'hE, 7'b0000001, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}, // R6 stop clears
        {4'h6, 4'hE, 7'b0000000, 4'b0010, 1'b0, 8'h00, 8'h02, 1'b0}, // R7 rx A
        {4'h6, 4'hE, 7'b0000000, 4'b0100, 1'b1, 8'h00, 8'h10, 1'b1}, // R10 zero mask readback
        {4'h6, 4'hE, 7'b0000000, 4'b1001, 1'b0, 8'h00, 8'h21, 1'b1}, // R1 R7 rx B, tx A
        {4'h6, 4'hE, 7'b0000000, 4'b1001, 1'b1, 8'h20, 8'h21, 1'b0}, // R9 one bit selected
        {4'h6, 4'hE, 7'b0000000, 4'b0000, 1'b0, 8'h00, 8'h00, 1'b1}  // R7 levels drop
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ip_pins = '0;
    logic [3:0] ip_chg_en = '0;
    logic       ipcr_rd = 1'b0, brk_evt_a = 1'b0, brk_evt_b = 1'b0;
    logic       brk_clr_a = 1'b0, brk_clr_b = 1'b0, ct_ready = 1'b0, ct_stop = 1'b0;
    logic       rx_req_a = 1'b0, tx_req_a = 1'b0, rx_req_b = 1'b0, tx_req_b = 1'b0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_din = '0;
    logic [7:0] status_o;
    logic       irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ip_pins   (ip_pins),
        .ip_chg_en (ip_chg_en),
        .ipcr_rd   (ipcr_rd),
        .brk_evt_a (brk_evt_a),
        .brk_evt_b (brk_evt_b),
        .brk_clr_a (brk_clr_a),
        .brk_clr_b (brk_clr_b),
        .ct_ready  (ct_ready),
        .ct_stop   (ct_stop),
        .rx_req_a  (rx_req_a),
        .tx_req_a  (tx_req_a),
        .rx_req_b  (rx_req_b),
        .tx_req_b  (tx_req_b),
        .mask_wr   (mask_wr),
        .mask_din  (mask_din),
        .status_o  (status_o),
        .irq_n     (irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_strobes();
        {ipcr_rd, brk_evt_a, brk_evt_b, brk_clr_a, brk_clr_b, ct_ready, ct_stop} = '0;
        mask_wr = 1'b0;
    endtask

    task automatic apply(input logic [36:0] v, input int idx);
        ip_pins   = v[36:33];
        ip_chg_en = v[32:29];
        {ipcr_rd, brk_evt_a, brk_evt_b, brk_clr_a, brk_clr_b, ct_ready, ct_stop} = v[28:22];
        {rx_req_b, tx_req_b, rx_req_a, tx_req_a} = v[21:18];
        mask_wr   = v[17];
        mask_din  = v[16:9];
        @(negedge clk);
        clear_strobes();
        @(negedge clk);
        check($sformatf("vector %0d status", idx), status_o, v[8:1]);
        check($sformatf("vector %0d irq_n", idx), {7'b0, irq_n}, {7'b0, v[0]});
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 status in reset", status_o, 8'h00);
        check("R11 irq_n in reset", {7'b0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 status after reset", status_o, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i], i);
        end

        // R8: mask write and event in the same cycle; line trails status by one clock
        brk_evt_a = 1'b1; mask_wr = 1'b1; mask_din = 8'h04;
        @(negedge clk);
        clear_strobes();
        check("R8 status first clock", status_o, 8'h04);
        check("R8 irq_n still high", {7'b0, irq_n}, 8'h01);
        @(negedge clk);
        check("R8 irq_n low next clock", {7'b0, irq_n}, 8'h00);

        // R11 and R2: reset mid-run with pins held non-zero; no spurious change after release
        ip_pins = 4'hF; ip_chg_en = 4'hF;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 status cleared by reset", status_o, 8'h00);
        check("R11 irq_n high in reset", {7'b0, irq_n}, 8'h01);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 no change on first sample", status_o, 8'h00);
        // R11: mask cleared by reset, so a new event keeps the line high
        brk_evt_b = 1'b1;
        @(negedge clk);
        clear_strobes();
        @(negedge clk);
        check("R11 mask zero after reset status", status_o, 8'h40);
        check("R11 mask zero after reset irq_n", {7'b0, irq_n}, 8'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule